// File: doc/BRIEF.md
# PC-Indexed Stride Learning Table

The block watches a stream of memory requests and learns, per load instruction, whether that instruction walks memory with a constant address step. Each request carries a data address, the program counter of the instruction that issued it, a flag saying whether that program counter is meaningful, a secure-world bit and a requester number. The program counter is folded into a set number. All ways of that set are then searched for an entry whose stored program counter and secure bit match. A matching entry is trained: its step, its saturating confidence counter and its remembered last address are updated. A request that finds no entry claims one way of the set, and that way starts over from a clean state.

Every trained or freshly allocated entry produces one result for a downstream prefetch-address generator. The result carries a hit flag, the step, the confidence and the address of the request. Requests enter and results leave over valid/ready handshakes. A request is taken on any edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the result register is empty or is being emptied in the same cycle. A result stays on the output, unchanged, until `out_ready` takes it. The table is made of flip-flops and is read combinationally. A request therefore always sees the effect of the request taken one edge earlier, with no extra hazard logic.

When `USE_REQ_ID` is set, every requester number owns a private copy of the table. When it is clear, all requesters share one copy.

Top module: `stride_table`

## Requirements
- R1: The set number is ((pc >> 1) XOR (pc >> (1 + log2 SETS))) masked to its low log2(SETS) bits. SETS is a power of two and at least 2. Entries in different sets never displace one another.
- R2: A request hits only if a valid way of its set holds both the same program counter and the same secure bit. The result reports this as `out_hit` = 1.
- R3: A request taken with `in_pc_ok` = 0 produces no result and changes no entry. `out_valid` is 0 on the following cycle.
- R4: On a hit where (request address − stored last address) equals the stored step and is not zero, confidence rises by one, stops at CONF_MAX, and the step is kept.
- R5: On a hit where that difference differs from the stored step or is zero, confidence falls by one and stops at CONF_MIN. If the lowered value is below CONF_THRESH, the step is replaced by the difference; otherwise the step is kept. Steps are two's complement, ADDR_W bits wide.
- R6: Every hit stores the request address as the entry's last address. Every result carries the request address in `out_addr`.
- R7: On a miss, the way taken is the lowest-numbered invalid way of the set. If the set is full, a way is chosen from a free-running pseudo-random sequence. The new entry gets the request's program counter, secure bit and address, a step of 0 and confidence CONF_START. The result reports `out_hit` = 0 with those values.
- R8: With USE_REQ_ID = 1, an entry written under one requester number is never hit under another requester number.
- R9: A request with `in_pc_ok` = 1 that is taken on an edge gives `out_valid` = 1 after that edge. `in_ready` equals (!`out_valid` || `out_ready`). While `out_valid` = 1 and `out_ready` = 0, every output field holds still.
- R10: During and right after reset, all entries are invalid, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The block can take a request this cycle |
| in_addr | input | ADDR_W | Data address of the request |
| in_pc | input | PC_W | Program counter of the issuing instruction |
| in_pc_ok | input | 1 | The program counter is meaningful; when 0, the request is dropped |
| in_secure | input | 1 | Secure-world bit, part of the match key |
| in_req_id | input | REQ_W | Requester number, selects a private table when USE_REQ_ID = 1 |
| out_valid | output | 1 | A result is offered |
| out_ready | input | 1 | The consumer takes the result |
| out_hit | output | 1 | 1 = an existing entry was trained, 0 = a new entry was allocated |
| out_stride | output | ADDR_W | Step held by the entry after the update (two's complement) |
| out_conf | output | CONF_W | Confidence held by the entry after the update |
| out_addr | output | ADDR_W | Address of the request that produced the result |

## Verification
Two things can happen on the same edge: one result is drained and the next request is taken. That next request often names the same instruction, so it must read the entry that was trained on the edge before. The bench provokes this by keeping `out_ready` high for most cycles and by sending long runs of requests to a few program counters. It also drops `out_ready` at random so that results are held and must stay frozen. Allocation and lookup also meet on one edge, when a miss into a full set evicts an entry that the following request tries to hit. The bench model does not try to guess the victim way. It marks every entry of that set as uncertain, accepts either outcome for those entries, and requires an exact hit, step and confidence for every entry whose survival is certain.

// File: rtl/stride_pkg.sv
package stride_pkg;

  // Free-running sequence used to pick a replacement way in a full set.
  localparam int LFSR_W = 16;
  typedef logic [LFSR_W-1:0] lfsr_t;

  // Nonzero start value and feedback mask (bits 15, 13, 12, 10).
  localparam lfsr_t LFSR_SEED = 16'hACE1;
  localparam lfsr_t LFSR_TAPS = 16'hB400;

endpackage

// File: rtl/stride_set_index.sv
// Folds program-counter bits into a set number: the bits just above
// bit 0 are XORed with the next group of the same width.
module stride_set_index #(
  parameter int IDX_W = 4
) (
  input  logic [2*IDX_W-1:0] pc_bits,   // pc[2*IDX_W:1]
  output logic [IDX_W-1:0]   set_idx
);

  logic [IDX_W-1:0] low_grp;
  logic [IDX_W-1:0] high_grp;

  always_comb begin
    low_grp  = pc_bits[IDX_W-1:0];
    high_grp = pc_bits[2*IDX_W-1:IDX_W];
    set_idx  = low_grp ^ high_grp;
  end

endmodule

// File: rtl/stride_trainer.sv
// Next step and next confidence for an entry that was hit.
module stride_trainer #(
  parameter int ADDR_W      = 32,
  parameter int CONF_W      = 3,
  parameter int CONF_MAX    = 7,
  parameter int CONF_MIN    = 0,
  parameter int CONF_THRESH = 4
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [ADDR_W-1:0] old_stride,
  input  logic [CONF_W-1:0] old_conf,
  output logic [ADDR_W-1:0] new_stride,
  output logic [CONF_W-1:0] new_conf
);

  localparam logic [CONF_W-1:0] C_MAX = CONF_W'(CONF_MAX);
  localparam logic [CONF_W-1:0] C_MIN = CONF_W'(CONF_MIN);
  localparam logic [CONF_W-1:0] C_TH  = CONF_W'(CONF_THRESH);
  localparam logic [CONF_W-1:0] C_ONE = CONF_W'(1);

  logic [ADDR_W-1:0] delta;
  logic              confirm;
  logic [CONF_W-1:0] raised;
  logic [CONF_W-1:0] lowered;

  always_comb begin
    delta   = req_addr - last_addr;
    confirm = (delta == old_stride) && (delta != '0);
    raised  = (old_conf < C_MAX) ? old_conf + C_ONE : old_conf;
    lowered = (old_conf > C_MIN) ? old_conf - C_ONE : old_conf;

    if (confirm) begin
      new_conf   = raised;
      new_stride = old_stride;
    end else begin
      new_conf   = lowered;
      // Retrain only after confidence has sunk under the issue level.
      new_stride = (lowered < C_TH) ? delta : old_stride;
    end
  end

endmodule

// File: rtl/stride_victim_pick.sv
// Chooses the way to fill on a miss: the lowest invalid way if one
// exists, otherwise a way drawn from a free-running LFSR.
module stride_victim_pick
  import stride_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  row_vld,
  output logic [WAY_W-1:0] vic_way
);

  lfsr_t            lfsr_q;
  logic [WAY_W-1:0] folded;
  logic [WAY_W-1:0] rand_way;
  logic [WAY_W-1:0] free_way;
  logic             have_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= LFSR_SEED;
    end else begin
      lfsr_q <= {lfsr_q[LFSR_W-2:0], ^(lfsr_q & LFSR_TAPS)};
    end
  end

  // Fold every LFSR bit into the way number, then wrap into range.
  always_comb begin
    folded = '0;
    for (int i = 0; i < LFSR_W; i++) begin
      folded[i % WAY_W] = folded[i % WAY_W] ^ lfsr_q[i];
    end
    if ({1'b0, folded} >= (WAY_W+1)'(WAYS)) begin
      rand_way = folded - WAY_W'(WAYS);
    end else begin
      rand_way = folded;
    end
  end

  always_comb begin
    have_free = 1'b0;
    free_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!row_vld[w]) begin
        have_free = 1'b1;
        free_way  = WAY_W'(w);
      end
    end
    vic_way = have_free ? free_way : rand_way;
  end

endmodule

// File: rtl/stride_table.sv
module stride_table
  import stride_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PC_W        = 32,
  parameter int SETS        = 16,
  parameter int WAYS        = 4,
  parameter int NUM_REQ     = 2,
  parameter bit USE_REQ_ID  = 1'b1,
  parameter int CONF_W      = 3,
  parameter int CONF_MAX    = 7,
  parameter int CONF_MIN    = 0,
  parameter int CONF_THRESH = 4,
  parameter int CONF_START  = 4,
  localparam int REQ_W      = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [PC_W-1:0]   in_pc,
  input  logic              in_pc_ok,
  input  logic              in_secure,
  input  logic [REQ_W-1:0]  in_req_id,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic [ADDR_W-1:0] out_stride,
  output logic [CONF_W-1:0] out_conf,
  output logic [ADDR_W-1:0] out_addr
);

  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int CTX_N = USE_REQ_ID ? NUM_REQ : 1;
  localparam int CTX_W = (CTX_N > 1) ? $clog2(CTX_N) : 1;
  localparam logic [CONF_W-1:0] C_START = CONF_W'(CONF_START);

  // ---------------------------------------------------------------
  // Entry storage, one table per context
  // ---------------------------------------------------------------
  logic              ent_vld    [CTX_N][SETS][WAYS];
  logic [PC_W-1:0]   ent_pc     [CTX_N][SETS][WAYS];
  logic              ent_sec    [CTX_N][SETS][WAYS];
  logic [ADDR_W-1:0] ent_last   [CTX_N][SETS][WAYS];
  logic [ADDR_W-1:0] ent_stride [CTX_N][SETS][WAYS];
  logic [CONF_W-1:0] ent_conf   [CTX_N][SETS][WAYS];

  logic              accept;
  logic              do_upd;
  logic [CTX_W-1:0]  ctx;
  logic [IDX_W-1:0]  set_idx;
  logic [WAYS-1:0]   row_vld;
  logic [WAYS-1:0]   hit_vec;
  logic              any_hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  vic_way;
  logic [WAY_W-1:0]  wr_way;
  logic [ADDR_W-1:0] sel_last;
  logic [ADDR_W-1:0] sel_stride;
  logic [CONF_W-1:0] sel_conf;
  logic [ADDR_W-1:0] trn_stride;
  logic [CONF_W-1:0] trn_conf;
  logic [ADDR_W-1:0] nxt_stride;
  logic [CONF_W-1:0] nxt_conf;

  // ---------------------------------------------------------------
  // Handshake
  // ---------------------------------------------------------------
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign do_upd   = accept && in_pc_ok;

  // ---------------------------------------------------------------
  // Context selection
  // ---------------------------------------------------------------
  generate
    if (USE_REQ_ID) begin : g_ctx_private
      assign ctx = CTX_W'(in_req_id);
    end else begin : g_ctx_shared
      assign ctx = '0;
    end
  endgenerate

  // ---------------------------------------------------------------
  // Set selection and tag search
  // ---------------------------------------------------------------
  stride_set_index #(
    .IDX_W (IDX_W)
  ) u_index (
    .pc_bits (in_pc[2*IDX_W:1]),
    .set_idx (set_idx)
  );

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      row_vld[w] = ent_vld[ctx][set_idx][w];
      hit_vec[w] = row_vld[w]
                   && (ent_pc[ctx][set_idx][w] == in_pc)
                   && (ent_sec[ctx][set_idx][w] == in_secure);
    end
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_way = WAY_W'(w);
      end
    end
    any_hit = |hit_vec;
  end

  assign sel_last   = ent_last[ctx][set_idx][hit_way];
  assign sel_stride = ent_stride[ctx][set_idx][hit_way];
  assign sel_conf   = ent_conf[ctx][set_idx][hit_way];

  // ---------------------------------------------------------------
  // Training and replacement
  // ---------------------------------------------------------------
  stride_trainer #(
    .ADDR_W      (ADDR_W),
    .CONF_W      (CONF_W),
    .CONF_MAX    (CONF_MAX),
    .CONF_MIN    (CONF_MIN),
    .CONF_THRESH (CONF_THRESH)
  ) u_train (
    .req_addr   (in_addr),
    .last_addr  (sel_last),
    .old_stride (sel_stride),
    .old_conf   (sel_conf),
    .new_stride (trn_stride),
    .new_conf   (trn_conf)
  );

  stride_victim_pick #(
    .WAYS  (WAYS),
    .WAY_W (WAY_W)
  ) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .row_vld (row_vld),
    .vic_way (vic_way)
  );

  assign wr_way     = any_hit ? hit_way : vic_way;
  assign nxt_stride = any_hit ? trn_stride : '0;
  assign nxt_conf   = any_hit ? trn_conf : C_START;

  // ---------------------------------------------------------------
  // Table update
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < CTX_N; c++) begin
        for (int s = 0; s < SETS; s++) begin
          for (int w = 0; w < WAYS; w++) begin
            ent_vld[c][s][w] <= 1'b0;
          end
        end
      end
    end else if (do_upd) begin
      ent_vld[ctx][set_idx][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_upd) begin
      ent_pc[ctx][set_idx][wr_way]     <= in_pc;
      ent_sec[ctx][set_idx][wr_way]    <= in_secure;
      ent_last[ctx][set_idx][wr_way]   <= in_addr;
      ent_stride[ctx][set_idx][wr_way] <= nxt_stride;
      ent_conf[ctx][set_idx][wr_way]   <= nxt_conf;
    end
  end

  // ---------------------------------------------------------------
  // Result register
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= in_pc_ok;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (do_upd) begin
      out_hit    <= any_hit;
      out_stride <= nxt_stride;
      out_conf   <= nxt_conf;
      out_addr   <= in_addr;
    end
  end

endmodule

// File: rtl/stride_table_chk.sv
module stride_table_chk #(
  parameter int ADDR_W     = 32,
  parameter int CONF_W     = 3,
  parameter int WAYS       = 4,
  parameter int CONF_MAX   = 7,
  parameter int CONF_MIN   = 0,
  parameter int CONF_START = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_pc_ok,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_hit,
  input logic [ADDR_W-1:0] out_stride,
  input logic [CONF_W-1:0] out_conf,
  input logic [ADDR_W-1:0] out_addr,
  input logic [WAYS-1:0]   hit_vec
);

  localparam logic [CONF_W-1:0] C_MAX   = CONF_W'(CONF_MAX);
  localparam logic [CONF_W-1:0] C_MIN   = CONF_W'(CONF_MIN);
  localparam logic [CONF_W-1:0] C_START = CONF_W'(CONF_START);

  AST_TAKEN_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_pc_ok) |=> out_valid);  // R9

  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_stride)
                                   && $stable(out_conf) && $stable(out_addr)));  // R9

  AST_NOPC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_pc_ok) |=> !out_valid);  // R3

  AST_CONF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_conf <= C_MAX && out_conf >= C_MIN));  // R4

  AST_MISS_CLEAN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_stride == '0 && out_conf == C_START));  // R7

  AST_SINGLE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0(hit_vec));  // R2

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);  // R10

endmodule

bind stride_table stride_table_chk #(
  .ADDR_W     (ADDR_W),
  .CONF_W     (CONF_W),
  .WAYS       (WAYS),
  .CONF_MAX   (CONF_MAX),
  .CONF_MIN   (CONF_MIN),
  .CONF_START (CONF_START)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_pc_ok   (in_pc_ok),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_hit    (out_hit),
  .out_stride (out_stride),
  .out_conf   (out_conf),
  .out_addr   (out_addr),
  .hit_vec    (hit_vec)
);

// File: tb/sim_stride_table.sv
module sim_stride_table;

  localparam int AW    = 32;
  localparam int PW    = 32;
  localparam int SETS  = 16;
  localparam int WAYS  = 4;
  localparam int NREQ  = 2;
  localparam int CW    = 3;
  localparam int CMAX  = 7;
  localparam int CMIN  = 0;
  localparam int CTH   = 4;
  localparam int CST   = 4;
  localparam int NPC   = 18;
  localparam int NKEY  = NPC * 4;
  localparam int NBKT  = NREQ * SETS;
  localparam int NDIR  = 27;
  localparam int NRAND = 4000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_addr = '0;
  logic [PW-1:0] in_pc = '0;
  logic          in_pc_ok = 1'b0;
  logic          in_secure = 1'b0;
  logic          in_req_id = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic          out_hit;
  logic [AW-1:0] out_stride;
  logic [CW-1:0] out_conf;
  logic [AW-1:0] out_addr;

  always #2 clk = ~clk;  // 250 MHz

  stride_table #(
    .ADDR_W(AW), .PC_W(PW), .SETS(SETS), .WAYS(WAYS), .NUM_REQ(NREQ),
    .USE_REQ_ID(1'b1), .CONF_W(CW), .CONF_MAX(CMAX), .CONF_MIN(CMIN),
    .CONF_THRESH(CTH), .CONF_START(CST)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_pc(in_pc), .in_pc_ok(in_pc_ok), .in_secure(in_secure),
    .in_req_id(in_req_id), .out_valid(out_valid), .out_ready(out_ready),
    .out_hit(out_hit), .out_stride(out_stride), .out_conf(out_conf), .out_addr(out_addr)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model, one slot per (pc, secure, requester) key
  bit          m_known [NKEY];
  bit          m_sure  [NKEY];
  logic [31:0] m_last  [NKEY];
  logic [31:0] m_str   [NKEY];
  int          m_conf  [NKEY];
  int          bcnt    [NBKT];
  logic [31:0] g_last  [NKEY];
  logic [31:0] g_pref  [NKEY];

  // Current request and pending result
  bit          r_valid, r_pcv;
  int          r_key;
  logic [31:0] r_addr;
  bit          pend, nopc_last, stalled;
  int          p_key;
  logic [31:0] p_addr;
  logic        s_hit;
  logic [31:0] s_str, s_addr;
  logic [CW-1:0] s_conf;
  int          dir_i = 0;
  int          sent = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pc_of(input int pi);
    if (pi < 6)       return 32'((pi + 1) << 9);   // all fold to set 0
    else if (pi < 12) return 32'(2 * (pi - 5));    // sets 1..6, low bits
    else              return 32'((pi - 11) << 5);  // sets 1..6, only via the XOR fold
  endfunction

  // R1 set number
  function automatic int set_of(input logic [31:0] pc);
    logic [31:0] h1, h2;
    h1 = pc >> 1;
    h2 = h1 >> $clog2(SETS);
    return int'((h1 ^ h2) & 32'(SETS - 1));
  endfunction

  function automatic int bkt_of(input int k);
    return (k % 2) * SETS + set_of(pc_of(k / 4));
  endfunction

  // R4 R5 expected training
  task automatic train(input logic [31:0] last, input logic [31:0] str, input int conf,
                       input logic [31:0] addr, output logic [31:0] ns, output int nc);
    logic [31:0] d;
    d = addr - last;
    if (d == str && d != 0) begin
      nc = (conf < CMAX) ? conf + 1 : conf;
      ns = str;
    end else begin
      nc = (conf > CMIN) ? conf - 1 : conf;
      ns = (nc < CTH) ? d : str;
    end
  endtask

  task automatic resolve();
    int k, b, nc;
    logic [31:0] ns;
    k = p_key;
    b = bkt_of(k);
    chk(out_addr == p_addr, "R6 result address", out_addr, p_addr);
    if (out_hit) begin
      chk(m_known[k], "R2 R8 hit without a stored entry", out_hit, 0);
      if (m_known[k]) begin
        train(m_last[k], m_str[k], m_conf[k], p_addr, ns, nc);
        chk(out_conf == CW'(nc), "R4 R5 confidence", out_conf, nc);
        chk(out_stride == ns, "R5 R6 stride", out_stride, ns);
        m_last[k] = p_addr; m_str[k] = ns; m_conf[k] = nc; m_sure[k] = 1;
      end
    end else begin
      chk(!(m_known[k] && m_sure[k]), "R1 R2 R7 stored entry missed", out_hit, 1);
      chk(out_stride == 0, "R7 fresh stride", out_stride, 0);
      chk(out_conf == CW'(CST), "R7 fresh confidence", out_conf, CST);
      if (bcnt[b] < WAYS) bcnt[b]++;
      else begin
        for (int kk = 0; kk < NKEY; kk++)
          if (kk != k && m_known[kk] && bkt_of(kk) == b) m_sure[kk] = 0;
      end
      m_known[k] = 1; m_sure[k] = 1; m_last[k] = p_addr; m_str[k] = 0; m_conf[k] = CST;
    end
  endtask

  task automatic directed(input int i);
    r_valid = 1; r_pcv = 1; r_key = 24;  // pc 2, non-secure, requester 0
    if (i < 8)        r_addr = 32'h2000 + 32'(64 * i);     // train to saturation (R4)
    else if (i == 8)  r_addr = 32'h2000 + 32'(64 * 7);     // zero step (R5)
    else if (i == 9)  r_addr = 32'h9000;                   // jump (R5)
    else if (i == 10) begin r_pcv = 0; r_addr = 32'h5555; end  // dropped (R3)
    else if (i == 11) r_addr = 32'h9040;                   // last address kept (R3 R6)
    else if (i == 12) begin r_key = 26; r_addr = 32'h9080; end // other secure bit (R2)
    else if (i == 13) begin r_key = 25; r_addr = 32'h9080; end // other requester (R8)
    else if (i == 14) r_addr = 32'h9080;
    else if (i < 19)  begin r_key = 28; r_addr = 32'h8000 - 32'(32 * (i - 15)); end // negative step
    else begin
      r_addr = 32'hB000 + 32'(16 * ((i - 19) * (i - 18) / 2)) + 32'h3;  // steady decay to CMIN (R5)
    end
    if (r_pcv) g_last[r_key] = r_addr;
  endtask

  task automatic gen_next();
    int pi, sel;
    if (dir_i < NDIR) begin
      directed(dir_i);
      dir_i++;
      return;
    end
    r_valid = ($urandom % 8) != 0;
    if (!r_valid) return;
    pi = $urandom % NPC;
    r_key = pi * 4 + int'($urandom % 2) * 2 + int'($urandom % 2);
    r_pcv = ($urandom % 16) != 0;
    sel = $urandom % 10;
    if (sel < 7)       r_addr = g_last[r_key] + g_pref[r_key];
    else if (sel == 7) r_addr = g_last[r_key];
    else if (sel == 8) r_addr = g_last[r_key] - g_pref[r_key];
    else               r_addr = $urandom;
    if (r_pcv) g_last[r_key] = r_addr;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_0017));
    for (int k = 0; k < NKEY; k++) begin
      m_known[k] = 0; m_sure[k] = 0;
      g_last[k] = 32'h1000_0000 + 32'(k) * 32'h0001_0000;
      case ($urandom % 4)
        0: g_pref[k] = 32'd64;
        1: g_pref[k] = -32'd64;
        2: g_pref[k] = 32'd8;
        default: g_pref[k] = 32'd4096;
      endcase
    end
    for (int b = 0; b < NBKT; b++) bcnt[b] = 0;
    pend = 0; nopc_last = 0; stalled = 0;

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 no result in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 no result after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R10 ready after reset", in_ready, 1);

    gen_next();
    while (sent < NDIR + NRAND) begin
      @(negedge clk);
      if (stalled)
        chk(out_valid && out_hit == s_hit && out_stride == s_str && out_conf == s_conf
            && out_addr == s_addr, "R9 held result", {out_valid, out_addr}, {1'b1, s_addr});
      chk(out_valid == pend, nopc_last ? "R3 dropped request result" : "R9 result timing",
          out_valid, pend);
      out_ready = (dir_i < NDIR) ? 1'b1 : (($urandom % 4) != 0);
      #1;
      chk(in_ready == (!out_valid || out_ready), "R9 ready rule", in_ready, !out_valid || out_ready);
      if (out_valid && out_ready) begin
        if (pend) resolve();
        pend = 0;
      end
      stalled = out_valid && !out_ready;
      s_hit = out_hit; s_str = out_stride; s_conf = out_conf; s_addr = out_addr;
      nopc_last = 0;
      in_valid = r_valid;
      if (r_valid) begin
        in_pc     = pc_of(r_key / 4);
        in_secure = r_key[1];
        in_req_id = r_key[0];
        in_addr   = r_addr;
        in_pc_ok  = r_pcv;
      end
      if (!r_valid) gen_next();
      else if (in_ready) begin
        if (r_pcv) begin pend = 1; p_key = r_key; p_addr = r_addr; end
        else nopc_last = 1;
        sent++;
        gen_next();
      end
    end

    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    #1;
    if (out_valid && pend) resolve();
    pend = 0;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R9 drained", out_valid, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule